// File: doc/BRIEF.md
# Standby Power Mode Controller

This block decides when a processor subsystem may drop into its deepest standby state and how it leaves it again. It watches the core's sleep indications (a wait-for-interrupt or wait-for-event pulse, a return-from-handler pulse together with the sleep-on-exit setting, and the deep-sleep request). It also watches a power-down enable bit and the selected real-time-clock wake source flags. When every entry condition holds, it raises a standby indication. When a condition fails, it falls back to an ordinary sleep indication.

Once in standby, the block floats every general I/O pad. A few pads stay alive: the reset pad, the wakeup pin when enabled, and two clock-domain alternate-function pads, according to their configured use. Any exit from standby goes through a reset request of fixed length, so execution restarts instead of resuming. Exits caused by a wake event set a wakeup flag and a standby flag, which survive that reset. Software uses them to tell a standby exit from a cold start, and clears them with write-one-to-clear strobes.

Top module: `standby_ctrl`

## Requirements
- R1: From run, a `wfx_i` pulse with `deep_req_i`=1, `pdn_en_i`=1, wakeup flag clear and the selected clock flag clear makes `standby_o` 1 from the next clock edge, with `sleep_o` and `sys_rst_o` 0.
- R2: `rtc_sel_i` picks bit 0..4 of `rtc_flags_i` (0 alarm A, 1 alarm B, 2 periodic wakeup, 3 tamper, 4 time stamp); values 5..7 select no flag. A `wfx_i` entry is refused when that bit is 1, the wakeup flag is 1, `deep_req_i` is 0 or `pdn_en_i` is 0; the block then shows `sleep_o`=1 and `standby_o`=0 from the next edge.
- R3: A pulse on `exit_isr_i` with `sleep_on_exit_i`=1 enters standby under the R1 conditions, except that the clock flags are not consulted. If the other conditions fail, it falls back to sleep. With `sleep_on_exit_i`=0, the pulse has no effect.
- R4: The wakeup pin passes a two-flop synchronizer. Only a low-to-high transition with `wk_pin_en_i`=1 is a wake event, and it ends standby at the third clock edge after the pin rises. A disabled pin, or a pin that stays high, does not wake.
- R5: Any `rtc_evt_i` bit (same order as R2) in standby raises `sys_rst_o`, and sets `wuf_o` and `sbf_o`, from the next edge.
- R6: `ext_rst_i` or `wdg_rst_i` in standby, run or sleep raises `sys_rst_o` from the next edge and leaves `wuf_o` and `sbf_o` unchanged.
- R7: `sys_rst_o` stays 1 for exactly RST_CYCLES (default 16) cycles. The block then returns to run with `standby_o`, `sleep_o` and `sys_rst_o` all 0.
- R8: `clr_wuf_i` and `clr_sbf_i` clear their flags at the next edge. A flag set in the same cycle wins over its clear.
- R9: Outside standby, `pad_hiz_o` is all zero. In standby, bit 0 (reset pad) is 0, bit 1 (wakeup pin) is 0 only when the pin is enabled, and every bit from 4 upward is 1. Bit 2 is 0 when `af1_mode_i` is 1..4 (1 tamper, 2 time stamp, 3 alarm out, 4 calibration out). Bit 3 is 0 when `af2_mode_i` is 1 or 2.
- R10: `dbg_clk_en_o` is 0 in standby and sleep unless `dbg_keep_i` is 1. It is 1 otherwise.
- R11: In sleep, a wake event (R4 or R5 source) returns to run on the next edge without a reset request and without changing the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Power-on reset, active low |
| wfx_i | input | 1 | Wait-for-interrupt/event executed (pulse) |
| exit_isr_i | input | 1 | Return from handler (pulse) |
| deep_req_i | input | 1 | Core deep-sleep request |
| sleep_on_exit_i | input | 1 | Core sleep-on-exit setting |
| pdn_en_i | input | 1 | Power-down in deep sleep enable |
| dbg_keep_i | input | 1 | Keep debug clock in low-power modes |
| rtc_sel_i | input | 3 | Selected clock wake source |
| rtc_flags_i | input | 5 | Clock wake source flags |
| wk_pin_i | input | 1 | Asynchronous wakeup pin |
| wk_pin_en_i | input | 1 | Wakeup pin enable |
| rtc_evt_i | input | 5 | Clock wake events |
| ext_rst_i | input | 1 | External reset pin asserted |
| wdg_rst_i | input | 1 | Watchdog reset |
| clr_wuf_i | input | 1 | Clear wakeup flag strobe |
| clr_sbf_i | input | 1 | Clear standby flag strobe |
| af1_mode_i | input | 3 | Use of first clock alternate pad |
| af2_mode_i | input | 3 | Use of second clock alternate pad |
| standby_o | output | 1 | Standby active |
| sleep_o | output | 1 | Ordinary sleep active |
| sys_rst_o | output | 1 | System reset request |
| wuf_o | output | 1 | Wakeup flag |
| sbf_o | output | 1 | Standby flag |
| pad_hiz_o | output | N_PADS | Per-pad high-impedance enable |
| dbg_clk_en_o | output | 1 | Debug clock enable |

## Verification
Entry decisions, clock wake events, external resets and flag clears act at the next clock edge. The pad and debug enables follow the state combinationally. A wakeup pin edge shows at the third edge because of the synchronizer and edge register. The bench drives every stimulus at a falling edge and samples at the following falling edge. For the pin, it samples the two intermediate falling edges (expecting standby still held) and then the third. The reset length is measured by counting the falling edges at which `sys_rst_o` is high.

// File: rtl/stby_pkg.sv
package stby_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_STBY  = 2'd2,
        ST_RST   = 2'd3
    } stby_state_e;

    localparam int unsigned N_RTC_SRC = 5;

    // alternate pad use codes
    localparam logic [2:0] AF_OFF    = 3'd0;
    localparam logic [2:0] AF_TAMPER = 3'd1;
    localparam logic [2:0] AF_TSTAMP = 3'd2;
    localparam logic [2:0] AF_ALARM  = 3'd3;
    localparam logic [2:0] AF_CALIB  = 3'd4;
endpackage

// File: rtl/stby_wkup_sync.sv
module stby_wkup_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    input  logic en_i,
    output logic rise_o
);
    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
        prev_d = sync_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign rise_o = en_i & sync_q[SYNC_STAGES-1] & ~prev_q;

    // R4: an accepted edge is a single-cycle event
    a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);
endmodule

// File: rtl/stby_pads.sv
module stby_pads #(
    parameter int unsigned N_PADS = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              stby_i,
    input  logic              wk_en_i,
    input  logic [2:0]        af1_mode_i,
    input  logic [2:0]        af2_mode_i,
    output logic [N_PADS-1:0] pad_hiz_o
);
    import stby_pkg::*;

    logic af1_keep, af2_keep;

    assign af1_keep = (af1_mode_i != AF_OFF) && (af1_mode_i <= AF_CALIB);
    assign af2_keep = (af2_mode_i == AF_TAMPER) || (af2_mode_i == AF_TSTAMP);

    for (genvar g = 0; g < N_PADS; g++) begin : g_pad
        if (g == 0) begin : g_rst_pad
            assign pad_hiz_o[g] = 1'b0;
        end else if (g == 1) begin : g_wk_pad
            assign pad_hiz_o[g] = stby_i & ~wk_en_i;
        end else if (g == 2) begin : g_af1_pad
            assign pad_hiz_o[g] = stby_i & ~af1_keep;
        end else if (g == 3) begin : g_af2_pad
            assign pad_hiz_o[g] = stby_i & ~af2_keep;
        end else begin : g_gp_pad
            assign pad_hiz_o[g] = stby_i;
        end
    end

    a_r9_no_float_awake: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stby_i |-> (pad_hiz_o == '0));
    a_r9_reset_pad_alive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stby_i |-> !pad_hiz_o[0]);
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl #(
    parameter int unsigned N_PADS      = 16,
    parameter int unsigned RST_CYCLES  = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wfx_i,
    input  logic              exit_isr_i,
    input  logic              deep_req_i,
    input  logic              sleep_on_exit_i,
    input  logic              pdn_en_i,
    input  logic              dbg_keep_i,
    input  logic [2:0]        rtc_sel_i,
    input  logic [4:0]        rtc_flags_i,
    input  logic              wk_pin_i,
    input  logic              wk_pin_en_i,
    input  logic [4:0]        rtc_evt_i,
    input  logic              ext_rst_i,
    input  logic              wdg_rst_i,
    input  logic              clr_wuf_i,
    input  logic              clr_sbf_i,
    input  logic [2:0]        af1_mode_i,
    input  logic [2:0]        af2_mode_i,
    output logic              standby_o,
    output logic              sleep_o,
    output logic              sys_rst_o,
    output logic              wuf_o,
    output logic              sbf_o,
    output logic [N_PADS-1:0] pad_hiz_o,
    output logic              dbg_clk_en_o
);
    import stby_pkg::*;

    localparam int unsigned CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

    typedef struct packed {
        stby_state_e      state;
        logic [CNT_W-1:0] cnt;
        logic             wuf;
        logic             sbf;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  pin_rise, wake_evt, hard_rst, sel_flag;
    logic  base_ok, go_wfx, go_isr, slp_req;

    stby_wkup_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (wk_pin_i),
        .en_i   (wk_pin_en_i),
        .rise_o (pin_rise)
    );

    always_comb begin
        sel_flag = 1'b0;
        for (int i = 0; i < N_RTC_SRC; i++) begin
            if (rtc_sel_i == 3'(i)) sel_flag = rtc_flags_i[i];
        end
    end

    assign wake_evt = pin_rise | (|rtc_evt_i);
    assign hard_rst = ext_rst_i | wdg_rst_i;
    assign base_ok  = deep_req_i & pdn_en_i & ~ctrl_q.wuf;
    assign go_wfx   = wfx_i & base_ok & ~sel_flag;
    assign go_isr   = exit_isr_i & sleep_on_exit_i & base_ok;
    assign slp_req  = wfx_i | (exit_isr_i & sleep_on_exit_i);

    always_comb begin
        ctrl_d = ctrl_q;
        if (clr_wuf_i) ctrl_d.wuf = 1'b0;
        if (clr_sbf_i) ctrl_d.sbf = 1'b0;
        unique case (ctrl_q.state)
            ST_RUN: begin
                if (hard_rst) begin
                    ctrl_d.state = ST_RST;
                    ctrl_d.cnt   = '0;
                end else if (go_wfx || go_isr) begin
                    ctrl_d.state = ST_STBY;
                end else if (slp_req) begin
                    ctrl_d.state = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (hard_rst) begin
                    ctrl_d.state = ST_RST;
                    ctrl_d.cnt   = '0;
                end else if (wake_evt) begin
                    ctrl_d.state = ST_RUN;
                end
            end
            ST_STBY: begin
                if (wake_evt) begin
                    ctrl_d.state = ST_RST;
                    ctrl_d.cnt   = '0;
                    ctrl_d.wuf   = 1'b1;
                    ctrl_d.sbf   = 1'b1;
                end else if (hard_rst) begin
                    ctrl_d.state = ST_RST;
                    ctrl_d.cnt   = '0;
                end
            end
            default: begin
                if (ctrl_q.cnt == CNT_LAST) begin
                    ctrl_d.state = ST_RUN;
                    ctrl_d.cnt   = '0;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '{state: ST_RUN, cnt: '0, wuf: 1'b0, sbf: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign standby_o    = (ctrl_q.state == ST_STBY);
    assign sleep_o      = (ctrl_q.state == ST_SLEEP);
    assign sys_rst_o    = (ctrl_q.state == ST_RST);
    assign wuf_o        = ctrl_q.wuf;
    assign sbf_o        = ctrl_q.sbf;
    assign dbg_clk_en_o = ~(standby_o | sleep_o) | dbg_keep_i;

    stby_pads #(.N_PADS(N_PADS)) u_pads (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .stby_i     (standby_o),
        .wk_en_i    (wk_pin_en_i),
        .af1_mode_i (af1_mode_i),
        .af2_mode_i (af2_mode_i),
        .pad_hiz_o  (pad_hiz_o)
    );

    a_r2_refuse_on_wuf: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sys_rst_o == 1'b0 && standby_o == 1'b0 && sleep_o == 1'b0
         && wfx_i && wuf_o && !hard_rst) |=> (sleep_o && !standby_o));
    a_r5_wake_sets_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (standby_o && (|rtc_evt_i)) |=> (sys_rst_o && wuf_o && sbf_o));
    a_r6_reset_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (standby_o && hard_rst && !wake_evt && !clr_wuf_i)
        |=> (sys_rst_o && wuf_o == $past(wuf_o)));
    a_r7_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_rst_o |-> (ctrl_q.cnt <= CNT_LAST));
    a_r8_clear_wuf: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_wuf_i && !standby_o) |=> !wuf_o);
    a_r10_dbg_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (standby_o && !dbg_keep_i) |-> !dbg_clk_en_o);
endmodule

// File: tb/standby_ctrl_tb.sv
`timescale 1ns/1ps
module standby_ctrl_tb;
    localparam int NP = 16;
    localparam int RC = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wfx = 0, exit_isr = 0, deep = 0, soe = 0, pdn = 0, dbg_keep = 0;
    logic [2:0] rsel = 0;
    logic [4:0] rflags = 0, revt = 0;
    logic wk_pin = 0, wk_en = 0, ext_rst = 0, wdg_rst = 0, clr_wuf = 0, clr_sbf = 0;
    logic [2:0] af1 = 0, af2 = 0;
    logic standby, sleep, sys_rst, wuf, sbf, dbg_en;
    logic [NP-1:0] hiz;

    int n_checks = 0;
    int n_err = 0;
    logic m_wuf = 0, m_sbf = 0;

    always #5 clk = ~clk;

    standby_ctrl #(.N_PADS(NP), .RST_CYCLES(RC), .SYNC_STAGES(2)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .wfx_i(wfx), .exit_isr_i(exit_isr),
        .deep_req_i(deep), .sleep_on_exit_i(soe), .pdn_en_i(pdn),
        .dbg_keep_i(dbg_keep), .rtc_sel_i(rsel), .rtc_flags_i(rflags),
        .wk_pin_i(wk_pin), .wk_pin_en_i(wk_en), .rtc_evt_i(revt),
        .ext_rst_i(ext_rst), .wdg_rst_i(wdg_rst), .clr_wuf_i(clr_wuf),
        .clr_sbf_i(clr_sbf), .af1_mode_i(af1), .af2_mode_i(af2),
        .standby_o(standby), .sleep_o(sleep), .sys_rst_o(sys_rst),
        .wuf_o(wuf), .sbf_o(sbf), .pad_hiz_o(hiz), .dbg_clk_en_o(dbg_en)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_hiz(input logic st, input logic en,
                                   input logic [2:0] m1, input logic [2:0] m2);
        logic [NP-1:0] v;
        if (!st) return 0;
        v = '1;
        v[0] = 1'b0;
        v[1] = !en;
        v[2] = !(m1 >= 3'd1 && m1 <= 3'd4);
        v[3] = !(m2 == 3'd1 || m2 == 3'd2);
        return int'(v);
    endfunction

    // path 0: wait instruction, path 1: handler return
    task automatic try_enter(input int path, input logic d, input logic p,
                             input logic [2:0] s, input logic [4:0] f,
                             input logic so, output logic exp_st);
        logic sflag, base, go, slp;
        @(negedge clk);
        deep = d; pdn = p; rsel = s; rflags = f; soe = so;
        wfx = (path == 0); exit_isr = (path == 1);
        sflag = (s < 5) ? f[s] : 1'b0;
        base  = d & p & !m_wuf;
        if (path == 0) begin go = base & !sflag; slp = 1'b1; end
        else begin go = so & base; slp = so; end
        @(negedge clk);
        wfx = 0; exit_isr = 0;
        exp_st = go;
        check(path == 0 ? "R1/R2 standby" : "R3 standby", int'(standby), int'(go));
        check(path == 0 ? "R2 sleep fallback" : "R3 sleep fallback", int'(sleep), int'(!go && slp));
    endtask

    task automatic check_reset_len(input string tag);
        int n = 0;
        while (sys_rst === 1'b1 && n < 100) begin
            n++;
            @(negedge clk);
        end
        check(tag, n, RC);
        check("R7 run after reset", int'({standby, sleep, sys_rst}), 0);
    endtask

    // src 0..4 clock event bit, 5 external reset, 6 watchdog
    task automatic wake_stby(input int src);
        @(negedge clk);
        if (src < 5) revt[src] = 1'b1;
        else if (src == 5) ext_rst = 1'b1;
        else wdg_rst = 1'b1;
        @(negedge clk);
        revt = 0; ext_rst = 0; wdg_rst = 0;
        if (src < 5) begin m_wuf = 1; m_sbf = 1; end
        check(src < 5 ? "R5 reset request" : "R6 reset request", int'(sys_rst), 1);
        check(src < 5 ? "R5 wuf" : "R6 wuf kept", int'(wuf), int'(m_wuf));
        check(src < 5 ? "R5 sbf" : "R6 sbf kept", int'(sbf), int'(m_sbf));
        check_reset_len("R7 reset length");
    endtask

    task automatic clear_flags();
        @(negedge clk);
        clr_wuf = 1; clr_sbf = 1;
        @(negedge clk);
        clr_wuf = 0; clr_sbf = 0;
        m_wuf = 0; m_sbf = 0;
        check("R8 wuf cleared", int'(wuf), 0);
        check("R8 sbf cleared", int'(sbf), 0);
    endtask

    initial begin
        #(150000 * 10);
        n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic st;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R7 reset standby", int'(standby), 0);
        check("R7 reset sleep", int'(sleep), 0);
        check("R7 reset sysrst", int'(sys_rst), 0);
        check("R8 reset flags", int'({wuf, sbf}), 0);
        check("R9 reset pads", int'(hiz), 0);
        check("R10 reset dbg", int'(dbg_en), 1);

        // R1 entry, R9 pads, R10 debug
        af1 = 3'd3; af2 = 3'd3; wk_en = 1;
        try_enter(0, 1, 1, 3'd0, 5'd0, 0, st);
        check("R9 pads alarm", int'(hiz), exp_hiz(1, 1, 3'd3, 3'd3));
        check("R10 dbg off", int'(dbg_en), 0);
        @(negedge clk);
        dbg_keep = 1; af1 = 3'd0; af2 = 3'd2; wk_en = 0;
        #1;
        check("R10 dbg kept", int'(dbg_en), 1);
        check("R9 pads mixed", int'(hiz), exp_hiz(1, 0, 3'd0, 3'd2));
        af1 = 3'd5; af2 = 3'd4;
        #1;
        check("R9 pads unused codes", int'(hiz), exp_hiz(1, 0, 3'd5, 3'd4));
        dbg_keep = 0;

        // R4 disabled pin does not wake
        wk_pin = 1;
        repeat (5) @(negedge clk);
        check("R4 disabled pin ignored", int'(standby), 1);
        wk_pin = 0;
        repeat (4) @(negedge clk);
        wk_en = 1;
        @(negedge clk);
        wk_pin = 1;
        @(negedge clk);
        check("R4 edge stage1", int'(standby), 1);
        @(negedge clk);
        check("R4 edge stage2", int'(standby), 1);
        @(negedge clk);
        check("R4 wake at third edge", int'(sys_rst), 1);
        m_wuf = 1; m_sbf = 1;
        check("R4 flags set", int'({wuf, sbf}), 3);
        check_reset_len("R7 reset length pin");

        // R4 pin still high: a fresh standby is not woken
        try_enter(0, 1, 1, 3'd0, 5'd0, 0, st);  // refused, wuf set
        check("R2 refused by wuf", int'(sleep), 1);
        @(negedge clk);
        revt[1] = 1;
        @(negedge clk);
        revt = 0;
        check("R11 sleep to run", int'({sleep, sys_rst}), 0);
        check("R11 flags untouched", int'({wuf, sbf}), 3);
        clear_flags();
        try_enter(0, 1, 1, 3'd0, 5'd0, 0, st);
        repeat (5) @(negedge clk);
        check("R4 held pin no wake", int'(standby), 1);
        wake_stby(5);
        wk_pin = 0;

        // R2 selected flag blocks, other flag does not
        try_enter(0, 1, 1, 3'd2, 5'b00100, 0, st);
        @(negedge clk); revt[0] = 1; @(negedge clk); revt = 0;
        check("R11 back to run", int'(sleep), 0);
        try_enter(0, 1, 1, 3'd2, 5'b00001, 0, st);
        check("R2 other flag ok", int'(standby), 1);
        wake_stby(6);

        // R3 handler return ignores clock flags; disabled sleep-on-exit
        try_enter(1, 1, 1, 3'd3, 5'b01000, 1, st);
        check("R3 entered despite flag", int'(standby), 1);
        // R8 set wins over clear
        @(negedge clk);
        revt[4] = 1; clr_wuf = 1;
        @(negedge clk);
        revt = 0; clr_wuf = 0;
        m_wuf = 1; m_sbf = 1;
        check("R8 set wins", int'(wuf), 1);
        check_reset_len("R7 reset length");
        clear_flags();
        try_enter(1, 1, 1, 3'd0, 5'd0, 0, st);
        check("R3 no effect without sleep-on-exit", int'({standby, sleep, sys_rst}), 0);

        // random trials
        for (int t = 0; t < 60; t++) begin
            int path = $urandom_range(0, 1);
            logic d = ($urandom_range(0, 3) != 0);
            logic p = ($urandom_range(0, 3) != 0);
            logic [2:0] s = 3'($urandom_range(0, 7));
            logic [4:0] f = 5'($urandom_range(0, 31)) & 5'($urandom_range(0, 31));
            logic so = ($urandom_range(0, 3) != 0);
            af1 = 3'($urandom_range(0, 7)); af2 = 3'($urandom_range(0, 7));
            wk_en = 1'($urandom_range(0, 1));
            try_enter(path, d, p, s, f, so, st);
            #1;
            check("R9 pads random", int'(hiz), exp_hiz(st, wk_en, af1, af2));
            if (st) begin
                wake_stby($urandom_range(0, 6));
            end else if (sleep) begin
                @(negedge clk); revt[2] = 1; @(negedge clk); revt = 0;
                check("R11 sleep exit", int'({sleep, sys_rst}), 0);
                check("R11 flags", int'({wuf, sbf}), int'({m_wuf, m_sbf}));
            end
            if ($urandom_range(0, 1) == 1) clear_flags();
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule